// File: doc/BRIEF.md
# Octant-Folded Sine Amplitude Converter

This block turns a 19-bit phase word into a 16-bit signed sine sample on every clock. It is meant to sit after a phase accumulator in a digital frequency synthesizer. The phase is split into three fields. The top three bits name one of eight 45-degree octants. The remaining sixteen bits are the position inside that octant.

Only the first octant (0 to π/4) is tabulated. The in-octant position is split again. Its upper seven bits pick a coarse sine/cosine pair. Its lower nine bits pick an angle increment. The coarse entries are held as small residues after a straight-line term has been removed, and an adder puts that term back. The increment table is a single table shared by all coarse entries. The correction is formed as the increment times the other path's coarse value and is added to the coarse value.

The octant code picks one of four reconstruction modes: sine positive, cosine positive, sine negated, or cosine negated. In odd octants the in-octant position is bit-inverted before the lookup. The block has four register stages:

- fold
- table read
- linear restore
- combine/round/saturate

Top module: `octsine_core`

## Requirements
- R1: While `rst_n` is low, and on each clock edge after release until the first result emerges, `sample_out` is 0.
- R2: A phase present at rising edge n appears on `sample_out` after rising edge n+3 and not earlier. A new phase may be applied on every clock.
- R3: Octant = phase bits [18:16], coarse index = bits [15:9], fine index = bits [8:0]. In odd octants bits [15:0] are bit-inverted before lookup, so phase 0x1FFFF yields exactly 32767.
- R4: For every phase p, `sample_out` is within ±2 LSB of round(32767·sin(2πp/2^19)).
- R5: For phases with bit 18 clear `sample_out` ≥ 0, and for phases with bit 18 set `sample_out` ≤ 0.
- R6: Half-wave antisymmetry is exact: out(p + 2^18) = −out(p) for p < 2^18.
- R7: Quarter-wave mirror is exact: out(2^17 + j) = out(2^17 − 1 − j) for 0 ≤ j < 2^17.
- R8: Anchor points are exact:
  - phase 0 → 0
  - 2^17 → 32767
  - 2^18 → 0
  - 3·2^17 → −32767
- R9: The code −32768 (0x8000) is never produced, so the output range is symmetric.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of all pipeline registers |
| phase_in | input | 19 | Phase word, full scale = one period |
| sample_out | output | 16 | Registered two's-complement sine sample |

## Verification
A bad octant decode or a wrong fold shows up at the ports as a wrong sign or a broken mirror pair. The mirror pairs hit are exact integer equalities, so a slip of one code is caught four clocks after the offending phase is applied.

A corrupt coarse residue or linear restore term moves whole 512-phase spans away from the ideal curve by far more than 2 LSB. The dense phase sweep therefore exposes it within the sweep.

A pipeline stage that is dropped or added shifts every result by a clock. The back-to-back stream check and the edge-by-edge latency check reveal that on the first changed phase.

// File: rtl/octsine_pkg.sv
package octsine_pkg;

    // phase field split
    localparam int OCT_W    = 3;
    localparam int COARSE_W = 7;
    localparam int FINE_W   = 9;
    localparam int OFF_W    = COARSE_W + FINE_W;
    localparam int PHASE_W  = OCT_W + OFF_W;

    // output and internal precision
    localparam int OUT_W      = 16;
    localparam int GUARD      = 4;
    localparam int AMP_W      = OUT_W + GUARD;
    localparam int SUM_W      = AMP_W + 2;
    localparam int RES_W      = 18;
    localparam int DELTA_FRAC = 20;
    localparam int DELTA_W    = 14;
    localparam int PROD_W     = SUM_W + DELTA_W + 1;
    localparam int MAXV       = (2 ** (OUT_W - 1)) - 1;
    localparam int AMP        = MAXV * (2 ** GUARD);

    localparam real PI_R  = 3.14159265358979323846;
    localparam real CSTEP = PI_R / 4.0 / real'(2 ** COARSE_W);
    localparam real FSTEP = PI_R / 4.0 / real'(2 ** OFF_W);

    typedef struct packed {
        logic [OCT_W-1:0]    oct;
        logic [COARSE_W-1:0] cidx;
        logic [FINE_W-1:0]   fidx;
    } fold_t;

    // reconstruction mode chosen by the octant code
    typedef enum logic [1:0] {
        RC_SIN_POS = 2'd0,
        RC_COS_POS = 2'd1,
        RC_SIN_NEG = 2'd2,
        RC_COS_NEG = 2'd3
    } recon_e;

    function automatic int round_r(real x);
        if (x >= 0.0) return $rtoi(x + 0.5);
        else          return -$rtoi(0.5 - x);
    endfunction

    function automatic int coarse_sin_amp(int idx);
        return round_r(real'(AMP) * $sin(real'(idx) * CSTEP));
    endfunction

    function automatic int coarse_cos_amp(int idx);
        return round_r(real'(AMP) * $cos(real'(idx) * CSTEP));
    endfunction

    // straight-line terms removed from the coarse entries
    localparam int LIN_S = round_r(real'(AMP) * $sin(PI_R / 4.0) / real'(2 ** COARSE_W));
    localparam int LIN_C = round_r(real'(AMP) * (1.0 - $cos(PI_R / 4.0)) / real'(2 ** COARSE_W));

    function automatic int sin_residue(int idx);
        return coarse_sin_amp(idx) - idx * LIN_S;
    endfunction

    function automatic int cos_residue(int idx);
        return coarse_cos_amp(idx) + idx * LIN_C - AMP;
    endfunction

    // angle increment in units of 2^-DELTA_FRAC radian
    function automatic int fine_delta(int f);
        return round_r(real'(f) * FSTEP * real'(2 ** DELTA_FRAC));
    endfunction

endpackage

// File: rtl/octsine_fold.sv
module octsine_fold
    import octsine_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] phase_in,
    output fold_t              fold_q
);

    logic [OCT_W-1:0] oct_d;
    logic [OFF_W-1:0] off_raw;
    logic [OFF_W-1:0] off_d;

    always_comb begin
        oct_d   = phase_in[PHASE_W-1:OFF_W];
        off_raw = phase_in[OFF_W-1:0];
        // odd octants run backwards through the first-octant tables
        off_d   = oct_d[0] ? ~off_raw : off_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fold_q <= '0;
        end else begin
            fold_q.oct  <= oct_d;
            fold_q.cidx <= off_d[OFF_W-1:FINE_W];
            fold_q.fidx <= off_d[FINE_W-1:0];
        end
    end

endmodule

// File: rtl/octsine_tables.sv
module octsine_tables
    import octsine_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  fold_t                      fold_in,
    output logic signed [RES_W-1:0]    res_sin_q,
    output logic signed [RES_W-1:0]    res_cos_q,
    output logic [DELTA_W-1:0]         delta_q,
    output logic [COARSE_W-1:0]        cidx_q,
    output logic [OCT_W-1:0]           oct_q
);

    localparam int N_COARSE = 2 ** COARSE_W;
    localparam int N_FINE   = 2 ** FINE_W;

    logic signed [RES_W-1:0] rom_sin [N_COARSE];
    logic signed [RES_W-1:0] rom_cos [N_COARSE];
    logic [DELTA_W-1:0]      rom_fine [N_FINE];

    for (genvar gi = 0; gi < N_COARSE; gi++) begin : g_coarse
        localparam int RS = sin_residue(gi);
        localparam int RC = cos_residue(gi);
        assign rom_sin[gi] = RES_W'(RS);
        assign rom_cos[gi] = RES_W'(RC);
    end

    for (genvar gf = 0; gf < N_FINE; gf++) begin : g_fine
        localparam int FD = fine_delta(gf);
        assign rom_fine[gf] = DELTA_W'(FD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_sin_q <= '0;
            res_cos_q <= '0;
            delta_q   <= '0;
            cidx_q    <= '0;
            oct_q     <= '0;
        end else begin
            res_sin_q <= rom_sin[fold_in.cidx];
            res_cos_q <= rom_cos[fold_in.cidx];
            delta_q   <= rom_fine[fold_in.fidx];
            cidx_q    <= fold_in.cidx;
            oct_q     <= fold_in.oct;
        end
    end

endmodule

// File: rtl/octsine_restore.sv
module octsine_restore
    import octsine_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [RES_W-1:0]    res_sin,
    input  logic signed [RES_W-1:0]    res_cos,
    input  logic [DELTA_W-1:0]         delta_in,
    input  logic [COARSE_W-1:0]        cidx,
    input  logic [OCT_W-1:0]           oct_in,
    output logic signed [SUM_W-1:0]    coarse_sin_q,
    output logic signed [SUM_W-1:0]    coarse_cos_q,
    output logic [DELTA_W-1:0]         delta_q,
    output logic [OCT_W-1:0]           oct_q
);

    localparam logic signed [SUM_W-1:0] AMP_S = SUM_W'(AMP);

    int lin_s;
    int lin_c;
    int sin_full;
    int cos_full;

    always_comb begin
        lin_s    = int'(cidx) * LIN_S;
        lin_c    = int'(cidx) * LIN_C;
        sin_full = int'(res_sin) + lin_s;
        cos_full = int'(res_cos) + AMP - lin_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coarse_sin_q <= '0;
            coarse_cos_q <= '0;
            delta_q      <= '0;
            oct_q        <= '0;
        end else begin
            coarse_sin_q <= SUM_W'(sin_full);
            coarse_cos_q <= SUM_W'(cos_full);
            delta_q      <= delta_in;
            oct_q        <= oct_in;
        end
    end

    // R4: restored first-octant coarse values stay within [0, AMP]
    a_r4_coarse_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_sin_q >= 0) && (coarse_sin_q <= AMP_S) &&
        (coarse_cos_q >= 0) && (coarse_cos_q <= AMP_S));

endmodule

// File: rtl/octsine_combine.sv
module octsine_combine
    import octsine_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SUM_W-1:0]    coarse_sin,
    input  logic signed [SUM_W-1:0]    coarse_cos,
    input  logic [DELTA_W-1:0]         delta_in,
    input  logic [OCT_W-1:0]           oct_in,
    output logic signed [OUT_W-1:0]    sample_q
);

    localparam logic signed [PROD_W-1:0] RND_P  = PROD_W'(2 ** (GUARD - 1));
    localparam logic signed [PROD_W-1:0] MAX_P  = PROD_W'(MAXV);
    localparam logic signed [OUT_W-1:0]  MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

    recon_e                   mode;
    logic signed [PROD_W-1:0] delta_s;
    logic signed [PROD_W-1:0] prod_cs;
    logic signed [PROD_W-1:0] prod_sc;
    logic signed [PROD_W-1:0] fine_sin;
    logic signed [PROD_W-1:0] fine_cos;
    logic signed [PROD_W-1:0] picked;
    logic signed [PROD_W-1:0] rounded;
    logic signed [OUT_W-1:0]  mag;
    logic signed [OUT_W-1:0]  sample_d;

    // octant code to reconstruction mode
    always_comb begin
        unique case (oct_in)
            3'd0:    mode = RC_SIN_POS;
            3'd1:    mode = RC_COS_POS;
            3'd2:    mode = RC_COS_POS;
            3'd3:    mode = RC_SIN_POS;
            3'd4:    mode = RC_SIN_NEG;
            3'd5:    mode = RC_COS_NEG;
            3'd6:    mode = RC_COS_NEG;
            default: mode = RC_SIN_NEG;
        endcase
    end

    always_comb begin
        delta_s  = PROD_W'($signed({1'b0, delta_in}));
        prod_cs  = PROD_W'(coarse_cos) * delta_s;
        prod_sc  = PROD_W'(coarse_sin) * delta_s;
        fine_sin = PROD_W'(coarse_sin) + (prod_cs >>> DELTA_FRAC);
        fine_cos = PROD_W'(coarse_cos) - (prod_sc >>> DELTA_FRAC);

        unique case (mode)
            RC_SIN_POS, RC_SIN_NEG: picked = fine_sin;
            default:                picked = fine_cos;
        endcase

        rounded = (picked + RND_P) >>> GUARD;
        if (rounded < 0)
            mag = '0;
        else if (rounded > MAX_P)
            mag = OUT_W'(MAXV);
        else
            mag = OUT_W'(rounded);

        unique case (mode)
            RC_SIN_NEG, RC_COS_NEG: sample_d = -mag;
            default:                sample_d = mag;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sample_q <= '0;
        else        sample_q <= sample_d;
    end

    // R9: the most negative code never appears
    a_r9_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
        sample_q != MIN_CODE);

    // R5: upper half-period octants give non-negative samples
    a_r5_sign_upper: assert property (@(posedge clk) disable iff (!rst_n)
        !oct_in[OCT_W-1] |=> sample_q >= 0);

    // R5: lower half-period octants give non-positive samples
    a_r5_sign_lower: assert property (@(posedge clk) disable iff (!rst_n)
        oct_in[OCT_W-1] |=> sample_q <= 0);

endmodule

// File: rtl/octsine_core.sv
module octsine_core
    import octsine_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PHASE_W-1:0]       phase_in,
    output logic signed [OUT_W-1:0]  sample_out
);

    fold_t                   fold_s1;
    logic signed [RES_W-1:0] res_sin_s2;
    logic signed [RES_W-1:0] res_cos_s2;
    logic [DELTA_W-1:0]      delta_s2;
    logic [COARSE_W-1:0]     cidx_s2;
    logic [OCT_W-1:0]        oct_s2;
    logic signed [SUM_W-1:0] csin_s3;
    logic signed [SUM_W-1:0] ccos_s3;
    logic [DELTA_W-1:0]      delta_s3;
    logic [OCT_W-1:0]        oct_s3;

    octsine_fold u_fold (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_in (phase_in),
        .fold_q   (fold_s1)
    );

    octsine_tables u_tables (
        .clk       (clk),
        .rst_n     (rst_n),
        .fold_in   (fold_s1),
        .res_sin_q (res_sin_s2),
        .res_cos_q (res_cos_s2),
        .delta_q   (delta_s2),
        .cidx_q    (cidx_s2),
        .oct_q     (oct_s2)
    );

    octsine_restore u_restore (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_sin      (res_sin_s2),
        .res_cos      (res_cos_s2),
        .delta_in     (delta_s2),
        .cidx         (cidx_s2),
        .oct_in       (oct_s2),
        .coarse_sin_q (csin_s3),
        .coarse_cos_q (ccos_s3),
        .delta_q      (delta_s3),
        .oct_q        (oct_s3)
    );

    octsine_combine u_combine (
        .clk        (clk),
        .rst_n      (rst_n),
        .coarse_sin (csin_s3),
        .coarse_cos (ccos_s3),
        .delta_in   (delta_s3),
        .oct_in     (oct_s3),
        .sample_q   (sample_out)
    );

    // edges seen since reset release, saturating at the pipeline depth
    logic [2:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age <= '0;
        else if (age != 3'd4) age <= age + 3'd1;
    end

    localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(2 ** (PHASE_W - 2));

    // R8: zero phase yields exactly zero, four edges later
    a_r8_zero_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 3'd4 && $past(phase_in, 4) == '0) |-> sample_out == '0);

    // R8: quarter-period phase yields the positive full-scale code
    a_r8_peak: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 3'd4 && $past(phase_in, 4) == QUARTER) |-> sample_out == OUT_W'(MAXV));

endmodule

// File: tb/test_octsine_core.sv
module test_octsine_core;

    logic               clk;
    logic               rst_n;
    logic [18:0]        phase_in;
    logic signed [15:0] sample_out;

    int n_checks;
    int n_fails;
    bit done;

    octsine_core i_octsine_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_in   (phase_in),
        .sample_out (sample_out)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic int ideal(int p);
        real v;
        v = 32767.0 * $sin(2.0 * 3.14159265358979323846 * real'(p) / 524288.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        else          return -$rtoi(0.5 - v);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic get_sample(input int p, output int s);
        @(negedge clk);
        phase_in = 19'(p);
        repeat (4) @(posedge clk);
        @(negedge clk);
        s = int'(sample_out);
    endtask

    task automatic t_reset();
        rst_n    = 1'b0;
        phase_in = 19'h2_0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sample_out == 0, "R1 during reset", int'(sample_out), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(sample_out == 0, "R1 after release", int'(sample_out), 0);
        end
        @(posedge clk);
        @(negedge clk);
        check(sample_out == 32767, "R2 first result", int'(sample_out), 32767);
    endtask

    task automatic t_anchors();
        int s;
        get_sample(0, s);            check(s == 0,      "R8 phase 0",      s, 0);
        get_sample(1 << 17, s);      check(s == 32767,  "R8 quarter",      s, 32767);
        get_sample(1 << 18, s);      check(s == 0,      "R8 half",         s, 0);
        get_sample(3 << 17, s);      check(s == -32767, "R8 three quarter", s, -32767);
    endtask

    task automatic t_latency();
        int seq [8];
        get_sample(0, seq[0]);
        @(negedge clk);
        phase_in = 19'(1 << 17);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(sample_out == 0, "R2 not early", int'(sample_out), 0);
        end
        @(posedge clk);
        @(negedge clk);
        check(sample_out == 32767, "R2 on time", int'(sample_out), 32767);
        // back-to-back stream, one phase per clock
        for (int k = 0; k < 8; k++) seq[k] = (k * 65011 + 777) % 524288;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (k >= 4) begin
                int e;
                e = ideal(seq[k-4]);
                check((int'(sample_out) - e) <= 2 && (e - int'(sample_out)) <= 2,
                      "R2 stream", int'(sample_out), e);
            end
            if (k < 8) phase_in = 19'(seq[k]);
        end
    endtask

    task automatic t_fields();
        int s;
        int e;
        get_sample(19'h1_FFFF, s);
        check(s == 32767, "R3 odd octant fold", s, 32767);
        for (int f = 0; f < 512; f += 73) begin
            int p;
            p = (5 << 16) | (42 << 9) | f;
            get_sample(p, s);
            e = ideal(p);
            check((s - e) <= 2 && (e - s) <= 2, "R3 fine field", s, e);
        end
    endtask

    task automatic t_sweep();
        int s;
        int e;
        int worst;
        int low;
        worst = 0;
        low   = 0;
        for (int p = 0; p < 524288; p += 97) begin
            get_sample(p, s);
            e = ideal(p);
            if ((s - e) > worst) worst = s - e;
            if ((e - s) > worst) worst = e - s;
            if (s < low) low = s;
            if ((s - e) > 2 || (e - s) > 2)
                check(1'b0, "R4 accuracy", s, e);
            if (p < 262144) begin
                if (s < 0) check(1'b0, "R5 sign upper", s, 0);
            end else begin
                if (s > 0) check(1'b0, "R5 sign lower", s, 0);
            end
        end
        check(worst <= 2, "R4 worst error", worst, 2);
        check(low > -32768, "R9 no min code", low, -32767);
    endtask

    task automatic t_halfwave();
        int a;
        int b;
        for (int p = 13; p < 262144; p += 2621) begin
            get_sample(p, a);
            get_sample(p + 262144, b);
            check(b == -a, "R6 antisymmetry", b, -a);
        end
    endtask

    task automatic t_mirror();
        int a;
        int b;
        for (int j = 0; j < 131072; j += 1871) begin
            get_sample(131072 + j, a);
            get_sample(131071 - j, b);
            check(a == b, "R7 quarter mirror", a, b);
        end
    endtask

    initial begin
        n_checks = 0;
        n_fails  = 0;
        done     = 1'b0;
        t_reset();
        t_anchors();
        t_latency();
        t_fields();
        t_sweep();
        t_halfwave();
        t_mirror();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule